// File: doc/BRIEF.md
# Wake Event and PHY Reset Controller

This block is a single 32-bit control and status register for power-management wake detection and a software-started PHY reset. Software reaches it through a plain register port: byte address, write data, write strobe, and a combinational read data bus. Two event inputs feed it. One is a pulse from the MAC's wake detector and the other is a pulse from the PHY's interrupt line, which flags energy detect or a link change.

Each event source has an enable bit. An event from an enabled source latches its own cause bit, and these bits are cleared by writing one to them. The same event also produces a one-cycle pulse that asks the power-management logic to set its event status.

A self-clearing bit drives the PHY reset. A cycle counter holds that reset for at least 100 µs, scaled from a clock-frequency parameter. While the hold runs, the block ignores every write to that bit.

Top module: `wake_rst_ctrl`

## Requirements
- R1: After reset, the register reads 0x0000_0000, and `phy_rst` and `pme_set` are low.
- R2: The register decodes only at byte address 0x0E0. A read at any other address returns zero, and a write there changes nothing. Bits 31:11, 7:5 and 2:0 always read zero.
- R3: Writing 1 to bit 10 raises `phy_rst` and bit 10 from the next cycle on. Both stay high for exactly HOLD_CYC = ceil(HOLD_US × CLK_HZ / 10^6) cycles, which is 12500 at the defaults, and then clear by themselves.
- R4: While bit 10 reads high, a write of 0 or 1 to bit 10 has no effect. The hold can be neither restarted nor cut short.
- R5: Bit 9 (MAC wake enable) and bit 8 (PHY event enable) are read/write and hold the written value.
- R6: When bit 9 is set, a cycle with `mac_wake` high sets status bit 4. It also drives `pme_set` high for exactly the following cycle.
- R7: When bit 8 is set, a cycle with `phy_irq` high sets status bit 3. It also drives `pme_set` high for exactly the following cycle.
- R8: An event whose enable bit is clear sets neither its status bit nor `pme_set`.
- R9: Writing 1 to status bit 4 or bit 3 clears that bit. Writing 0 leaves it unchanged.
- R10: If an enabled event and a write of 1 to the same status bit fall in the same cycle, the bit stays set.
- R11: Asserting `rst` clears every bit and ends any PHY reset that is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high device reset |
| reg_addr | input | 12 | Byte address of the access |
| reg_wdata | input | 32 | Write data |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| mac_wake | input | 1 | MAC wake-detect event pulse |
| phy_irq | input | 1 | PHY interrupt (energy detect / link change) pulse |
| phy_rst | output | 1 | PHY reset, active high |
| pme_set | output | 1 | One-cycle request to set PM event status |

## Verification
The bench measures the full length of the PHY reset hold. It does this once without interference and once with writes of both 0 and 1 to bit 10 in the middle of the hold. A design that restarted or cut the timer would give a count other than 12500.

The bench also pulses each event source with its enable clear and checks that neither the status bit nor the PM event pulse appears. It exercises write-one-to-clear on one bit while the other bit holds a 0, and it clears a bit in the same cycle that its event arrives. A design where the clear won would lose that wake cause.

Finally, it checks that a write at a neighbouring address leaves the register untouched, and that a device reset in the middle of a hold releases the PHY at once.

// File: rtl/wake_rst_pkg.sv
package wake_rst_pkg;

    // Bit positions inside the control/status word
    localparam int BIT_PHY_RST = 10;
    localparam int BIT_MAC_EN  = 9;
    localparam int BIT_ED_EN   = 8;
    localparam int BIT_STS_MAC = 4;
    localparam int BIT_STS_PHY = 3;

    typedef struct packed {
        logic mac;
        logic phy;
    } wake_src_t;

    typedef struct packed {
        logic mac_en;
        logic ed_en;
    } wake_en_t;

    // ceil(us * clk_hz / 1e6), never below one cycle
    function automatic int hold_cycles(input longint clk_hz, input longint us);
        longint c;
        c = (clk_hz * us + 64'd999_999) / 64'd1_000_000;
        if (c < 1) c = 1;
        return int'(c);
    endfunction

    function automatic logic [31:0] pack_word(input logic rst_bit,
                                              input wake_en_t en,
                                              input wake_src_t sts);
        logic [31:0] w;
        w = '0;
        w[BIT_PHY_RST] = rst_bit;
        w[BIT_MAC_EN]  = en.mac_en;
        w[BIT_ED_EN]   = en.ed_en;
        w[BIT_STS_MAC] = sts.mac;
        w[BIT_STS_PHY] = sts.phy;
        return w;
    endfunction

endpackage

// File: rtl/wake_rst_hold_timer.sv
module wake_rst_hold_timer #(
    parameter int HOLD_CYC = 12500
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    localparam int CNT_W = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYC - 1);

    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (busy_q) begin
            if (cnt_q == LAST) begin
                busy_q <= 1'b0;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
        end
    end

    assign busy = busy_q;
endmodule

// File: rtl/wake_rst_status.sv
module wake_rst_status
    import wake_rst_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  wake_src_t evt,
    input  wake_en_t  en,
    input  wake_src_t clr,
    output wake_src_t sts,
    output logic      pme
);
    wake_src_t hit;
    wake_src_t sts_q;
    logic      pme_q;

    always_comb begin
        hit.mac = evt.mac & en.mac_en;
        hit.phy = evt.phy & en.ed_en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sts_q <= '0;
            pme_q <= 1'b0;
        end else begin
            sts_q <= (sts_q & ~clr) | hit;
            pme_q <= |hit;
        end
    end

    assign sts = sts_q;
    assign pme = pme_q;
endmodule

// File: rtl/wake_rst_ctrl.sv
module wake_rst_ctrl
    import wake_rst_pkg::*;
#(
    parameter longint CLK_HZ  = 125_000_000,
    parameter longint HOLD_US = 100,
    parameter int     ADDR_W  = 12,
    parameter int     REG_OFF = 12'h0E0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic              reg_wr,
    output logic [31:0]       reg_rdata,
    input  logic              mac_wake,
    input  logic              phy_irq,
    output logic              phy_rst,
    output logic              pme_set
);
    localparam int HOLD_CYC = hold_cycles(CLK_HZ, HOLD_US);

    logic      hit_q;
    logic      wr_hit;
    wake_en_t  en_q;
    wake_src_t clr;
    wake_src_t evt;
    wake_src_t sts;
    logic      busy;

    always_comb begin
        hit_q   = (reg_addr == ADDR_W'(REG_OFF));
        wr_hit  = reg_wr & hit_q;
        clr.mac = wr_hit & reg_wdata[BIT_STS_MAC];
        clr.phy = wr_hit & reg_wdata[BIT_STS_PHY];
        evt.mac = mac_wake;
        evt.phy = phy_irq;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (wr_hit) begin
            en_q.mac_en <= reg_wdata[BIT_MAC_EN];
            en_q.ed_en  <= reg_wdata[BIT_ED_EN];
        end
    end

    wake_rst_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .start(wr_hit & reg_wdata[BIT_PHY_RST]),
        .busy (busy)
    );

    wake_rst_status u_status (
        .clk(clk),
        .rst(rst),
        .evt(evt),
        .en (en_q),
        .clr(clr),
        .sts(sts),
        .pme(pme_set)
    );

    assign phy_rst   = busy;
    assign reg_rdata = hit_q ? pack_word(busy, en_q, sts) : 32'h0;
endmodule

// File: rtl/wake_rst_chk.sv
module wake_rst_chk #(
    parameter int HOLD_CYC = 12500
) (
    input logic       clk,
    input logic       rst,
    input logic       mac_wake,
    input logic       phy_irq,
    input logic       mac_en,
    input logic       ed_en,
    input logic       wr_hit,
    input logic [1:0] wsts,
    input logic [1:0] sts,
    input logic       phy_rst,
    input logic       pme_set
);
    int hi_cnt;

    always_ff @(posedge clk) begin
        if (rst || !phy_rst) hi_cnt <= 0;
        else                 hi_cnt <= hi_cnt + 1;
    end

    p_rst_clears_r11: assert property (@(posedge clk)
        rst |=> (!phy_rst && !pme_set && sts == 2'b00));

    p_hold_len_r3: assert property (@(posedge clk) disable iff (rst)
        ($fell(phy_rst) && $past(!rst)) |-> (hi_cnt == HOLD_CYC));

    p_hold_max_r4: assert property (@(posedge clk) disable iff (rst)
        phy_rst |-> (hi_cnt < HOLD_CYC));

    p_pme_cause_r8: assert property (@(posedge clk) disable iff (rst)
        pme_set |-> $past((mac_wake && mac_en) || (phy_irq && ed_en)));

    p_mac_set_r6: assert property (@(posedge clk) disable iff (rst)
        (mac_wake && mac_en) |=> (sts[1] && pme_set));

    p_phy_set_r7: assert property (@(posedge clk) disable iff (rst)
        (phy_irq && ed_en) |=> (sts[0] && pme_set));

    p_w1c_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && wsts[1] && !(mac_wake && mac_en)) |=> !sts[1]);
endmodule

bind wake_rst_ctrl wake_rst_chk #(.HOLD_CYC(HOLD_CYC)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .mac_wake(mac_wake),
    .phy_irq (phy_irq),
    .mac_en  (en_q.mac_en),
    .ed_en   (en_q.ed_en),
    .wr_hit  (wr_hit),
    .wsts    (reg_wdata[4:3]),
    .sts     (sts),
    .phy_rst (phy_rst),
    .pme_set (pme_set)
);

// File: tb/wake_rst_ctrl_tb.sv
module wake_rst_ctrl_tb;
    localparam int HOLD = 12500;
    localparam logic [11:0] OFF = 12'h0E0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } rd_item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] reg_addr = OFF;
    logic [31:0] reg_wdata = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_rdata;
    logic        mac_wake = 1'b0;
    logic        phy_irq = 1'b0;
    logic        phy_rst;
    logic        pme_set;

    int n_chk = 0;
    int n_bad = 0;
    int hi_cnt = 0;
    logic rd_go = 1'b0;
    logic done = 1'b0;
    rd_item_t sb_q[$];

    always #4 clk = ~clk;

    wake_rst_ctrl u_dut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_wr(reg_wr), .reg_rdata(reg_rdata), .mac_wake(mac_wake),
        .phy_irq(phy_irq), .phy_rst(phy_rst), .pme_set(pme_set)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: pops expected read data and compares
    always @(negedge clk) begin
        if (rd_go && sb_q.size() > 0) begin
            rd_item_t it;
            it = sb_q.pop_front();
            check(reg_rdata, it.exp, it.tag);
        end
        if (phy_rst) hi_cnt++;
    end

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(posedge clk); #1;
        reg_addr = a;
        sb_q.push_back('{exp, tag});
        rd_go = 1'b1;
        @(negedge clk); #1;
        rd_go = 1'b0;
        reg_addr = OFF;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); #1;
        reg_wr = 1'b0; reg_addr = OFF; reg_wdata = '0;
    endtask

    task automatic pulse(input logic m, input logic p, input logic exp_pme, input string tag);
        @(posedge clk); #1;
        mac_wake = m; phy_irq = p;
        @(posedge clk); #1;
        mac_wake = 0; phy_irq = 0;
        @(negedge clk);
        check({31'b0, pme_set}, {31'b0, exp_pme}, {tag, " pme pulse"});
        @(negedge clk);
        check({31'b0, pme_set}, 32'h0, {tag, " pme single cycle"});
    endtask

    task automatic wait_release();
        while (phy_rst) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1
        @(negedge clk);
        check({30'b0, phy_rst, pme_set}, 32'h0, "R1 outputs after reset");
        rd(OFF, 32'h0, "R1 register after reset");
        // R5 and R2
        wr(OFF, 32'h0000_0300);
        rd(OFF, 32'h0000_0300, "R5 enables set");
        wr(OFF, 32'h0000_0000);
        rd(OFF, 32'h0000_0000, "R5 enables cleared");
        wr(OFF, 32'hFFFF_FBE7);
        rd(OFF, 32'h0000_0300, "R2 reserved bits read zero");
        wr(12'h0E4, 32'h0000_0000);
        rd(OFF, 32'h0000_0300, "R2 write elsewhere ignored");
        rd(12'h0E4, 32'h0, "R2 read elsewhere zero");
        // R8: MAC disabled, PHY enabled
        wr(OFF, 32'h0000_0100);
        pulse(1, 0, 0, "R8 disabled mac");
        rd(OFF, 32'h0000_0100, "R8 disabled mac leaves status");
        // R7
        pulse(0, 1, 1, "R7 phy event");
        rd(OFF, 32'h0000_0108, "R7 phy status bit3");
        // R9 write 0 leaves; R6
        wr(OFF, 32'h0000_0300);
        rd(OFF, 32'h0000_0308, "R9 write zero keeps bit3");
        pulse(1, 0, 1, "R6 mac event");
        rd(OFF, 32'h0000_0318, "R6 mac status bit4");
        wr(OFF, 32'h0000_0310);
        rd(OFF, 32'h0000_0308, "R9 clear bit4 only");
        wr(OFF, 32'h0000_0308);
        rd(OFF, 32'h0000_0300, "R9 clear bit3");
        // R10: clear and event in the same cycle
        @(posedge clk); #1;
        reg_wdata = 32'h0000_0308; reg_wr = 1'b1; phy_irq = 1'b1;
        @(posedge clk); #1;
        reg_wr = 1'b0; reg_wdata = '0; phy_irq = 1'b0;
        rd(OFF, 32'h0000_0308, "R10 event beats clear");
        wr(OFF, 32'h0000_0308);
        // R3: plain hold
        hi_cnt = 0;
        wr(OFF, 32'h0000_0700);
        check({31'b0, phy_rst}, 32'h1, "R3 phy_rst rises");
        rd(OFF, 32'h0000_0700, "R3 bit10 reads high");
        wait_release();
        check(32'(hi_cnt), 32'(HOLD), "R3 hold length");
        rd(OFF, 32'h0000_0300, "R3 bit10 self-clears");
        // R4: writes during hold ignored
        hi_cnt = 0;
        wr(OFF, 32'h0000_0700);
        repeat (100) @(posedge clk);
        wr(OFF, 32'h0000_0300);
        check({31'b0, phy_rst}, 32'h1, "R4 write 0 does not cut hold");
        repeat (100) @(posedge clk);
        wr(OFF, 32'h0000_0700);
        wait_release();
        check(32'(hi_cnt), 32'(HOLD), "R4 hold not restarted");
        // R11
        wr(OFF, 32'h0000_0700);
        pulse(1, 1, 1, "R11 prep events");
        @(posedge clk); #1 rst = 1'b1;
        @(posedge clk); #1 rst = 1'b0;
        @(negedge clk);
        check({31'b0, phy_rst}, 32'h0, "R11 reset ends phy reset");
        rd(OFF, 32'h0, "R11 register cleared");
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule